// File: doc/BRIEF.md
# Sized Asynchronous Bus-Cycle Master

This block moves one operand of one to four bytes across an external bus. On that bus every cycle is ended by the addressed slave, not by a fixed count of clocks. A client hands over a start address, an operand length, a direction and an address-space tag. The master then runs as many strobed bus cycles as the slave's port width requires and pulses a completion flag when the last byte has moved. For reads, the assembled operand comes back with the completion flag.

Each cycle puts several fields on the bus at the same time, and they stay frozen until the slave acknowledges:

- the address of the first byte of that cycle;
- a code giving how many operand bytes are still outstanding;
- a three-bit address-space tag;
- the read/write line.

The slave answers with a two-bit code that gives its port width. From that code the master works out how many bytes were taken. It then advances the address, shrinks the outstanding count and, after at least one clock with the strobe low, opens the next cycle. Data travels on the top byte lanes of the 32-bit data paths.

Top module: `sized_bus_master`

## Requirements
- R1: Address, size code, space code, read/write line and write data change only on the clock edge that raises the strobe or on the edge that ends a cycle. While the strobe is high and no acknowledge has been sampled, they hold their values and the strobe stays high.
- R2: The address of each cycle is the address of the first operand byte that the cycle moves. The next cycle's address is the previous one plus the bytes accepted, taken modulo 2^24, so 0xFFFFFF is followed by 0x000000.
- R3: The size code gives the operand bytes still outstanding at the start of the cycle: 01 is one byte, 10 is two, 11 is three and 00 is four. The request's length input uses the same encoding.
- R4: The read/write line is 1 for read and 0 for write, and comes out of reset at 1. It changes only on the edge that raises the strobe, and only when the new transfer's direction differs from the last one. Consecutive writes keep it at 0.
- R5: The space codes 001, 010, 101, 110 and 111 are issued as requested. A request tagged 000, 011 or 100 is ignored: no strobe, no completion pulse, and the block stays ready.
- R6: While the acknowledge code is 00, the master keeps the cycle open for as many clocks as the slave takes.
- R7: Acknowledge code 01 means an 8-bit port, 10 a 16-bit port and 11 a 32-bit port. In one cycle the master moves the smaller of the port's byte count and the bytes outstanding.
- R8: The write operand is the low N bytes of the request data, most significant byte first. The outstanding bytes sit left-justified on the data output, with the next byte on bits 31:24 and zeros below the last byte.
- R9: For reads, each cycle takes the top lanes of the input data, one byte per byte accepted with bits 31:24 first. The result is right-justified in the read-data output, with the first byte received most significant.
- R10: The strobe falls on the edge after the acknowledge is sampled and stays low for at least one clock before the next cycle. The completion flag is high for exactly one clock, on the edge that ends the final cycle. The ready output is high only while no transfer is in progress, and the strobe is then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when ready is high |
| req_ready | output | 1 | Idle, able to take a request |
| req_addr | input | 24 | Address of the operand's first byte |
| req_size | input | 2 | Operand length code (00 means 4 bytes) |
| req_write | input | 1 | 1 for a write operand |
| req_space | input | 3 | Address-space tag |
| req_wdata | input | 32 | Write operand, right-justified |
| bus_addr | output | 24 | Cycle address |
| bus_siz | output | 2 | Outstanding-bytes code |
| bus_fc | output | 3 | Address-space code |
| bus_rw | output | 1 | 1 read, 0 write |
| bus_as | output | 1 | Address strobe, active high |
| bus_dout | output | 32 | Write data, left-justified |
| bus_ack | input | 2 | Port-width acknowledge, 00 means wait |
| bus_din | input | 32 | Read data from the slave |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Assembled read operand |

## Verification
A behavioural slave model replies with a chosen port width after a chosen number of wait clocks. A queue of expected cycles, built from the request, is compared against every strobe rise, and the bench checks on every clock that the fields hold while the acknowledge is absent. The corner cases are:

- Three-byte operands on 16-bit ports: a wrong take-the-minimum rule over-runs the count or emits a bogus size code.
- Four single-byte cycles on an 8-bit port: an off-by-one count shows up here.
- An address wrap at the top of the 24-bit space: a carry into a wider register, or a failure to wrap, shows up as a wrong cycle address.
- A forty-clock wait: a master that times out or lets the fields drift during the wait is caught.
- Same-direction transfers in a row: any spurious read/write toggle is flagged.
- Requests with reserved space codes: a master that issues them shows an unexpected strobe.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } sbm_state_t;

  // Address-space tags that may appear on the bus
  function automatic logic fc_legal(input logic [2:0] fc);
    return (fc == 3'b001) || (fc == 3'b010) || (fc == 3'b101) ||
           (fc == 3'b110) || (fc == 3'b111);
  endfunction

endpackage

// File: rtl/sbm_step.sv
// Decodes the slave's port-width answer and works out how many bytes the
// current cycle moved and how many remain afterwards.
module sbm_step #(
  parameter int LANES = 4,
  parameter int CNT_W = $clog2(LANES + 1),
  parameter int SZ_W  = $clog2(LANES)
) (
  input  logic [CNT_W-1:0] rem,
  input  logic [SZ_W-1:0]  bus_ack,
  output logic             acked,
  output logic [CNT_W-1:0] take,
  output logic [CNT_W-1:0] rem_next
);

  logic [CNT_W:0] port_bytes;

  always_comb begin
    port_bytes = '0;
    if (bus_ack != '0) begin
      port_bytes = (CNT_W + 1)'(1) << (bus_ack - 1'b1);
    end
  end

  assign acked    = (bus_ack != '0);
  assign take     = ({1'b0, rem} < port_bytes) ? rem : port_bytes[CNT_W-1:0];
  assign rem_next = rem - take;

endmodule

// File: rtl/sbm_lanes.sv
// Write data shifter and read data accumulator on big-endian byte lanes.
module sbm_lanes #(
  parameter int LANES  = 4,
  parameter int CNT_W  = $clog2(LANES + 1),
  parameter int DATA_W = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              step,
  input  logic [CNT_W-1:0]  take,
  input  logic [DATA_W-1:0] din,
  input  logic              final_rd,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] wr_shift;
  logic [DATA_W-1:0] rd_acc;
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] rd_top;

  // Bytes taken from the top lanes, moved down to the low end
  assign rd_top  = din >> (DATA_W - 8 * int'(take));
  assign rd_next = (rd_acc << (8 * int'(take))) | rd_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_shift <= '0;
      rd_acc   <= '0;
      rdata    <= '0;
    end else begin
      if (load) begin
        wr_shift <= wdata << (8 * (LANES - int'(load_cnt)));
        rd_acc   <= '0;
      end else if (step) begin
        wr_shift <= wr_shift << (8 * int'(take));
        rd_acc   <= rd_next;
      end
      if (final_rd) begin
        rdata <= rd_next;
      end
    end
  end

  assign dout = wr_shift;

endmodule

// File: rtl/sbm_ctrl.sv
// Cycle sequencer: opens strobed cycles, waits for the slave, inserts the
// strobe-low gap and keeps the per-cycle bus fields registered.
module sbm_ctrl
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LANES  = 4,
  parameter int CNT_W  = $clog2(LANES + 1),
  parameter int SZ_W   = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SZ_W-1:0]   req_size,
  input  logic              req_write,
  input  logic [2:0]        req_space,
  input  logic              acked,
  input  logic [CNT_W-1:0]  take,
  input  logic [CNT_W-1:0]  rem_next,
  output logic              req_ready,
  output logic              accept,
  output logic [CNT_W-1:0]  load_cnt,
  output logic              step,
  output logic              last_rd,
  output logic [CNT_W-1:0]  rem_q,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [SZ_W-1:0]   bus_siz,
  output logic [2:0]        bus_fc,
  output logic              bus_rw,
  output logic              bus_as,
  output logic              done
);

  function automatic logic [SZ_W-1:0] code_of(input logic [CNT_W-1:0] n);
    return (n == CNT_W'(LANES)) ? '0 : n[SZ_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] count_of(input logic [SZ_W-1:0] c);
    return (c == '0) ? CNT_W'(LANES) : CNT_W'(c);
  endfunction

  sbm_state_t state;
  logic       wr_q;
  logic       last;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid && fc_legal(req_space);
  assign load_cnt  = count_of(req_size);
  assign step      = (state == ST_RUN) && acked;
  assign last      = step && (rem_next == '0);
  assign last_rd   = last && !wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wr_q     <= 1'b0;
      rem_q    <= '0;
      bus_addr <= '0;
      bus_siz  <= '0;
      bus_fc   <= '0;
      bus_rw   <= 1'b1;
      bus_as   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_RUN;
            wr_q     <= req_write;
            rem_q    <= load_cnt;
            bus_addr <= req_addr;
            bus_siz  <= req_size;
            bus_fc   <= req_space;
            bus_rw   <= !req_write;
            bus_as   <= 1'b1;
          end
        end
        ST_RUN: begin
          if (acked) begin
            bus_as   <= 1'b0;
            rem_q    <= rem_next;
            bus_siz  <= code_of(rem_next);
            bus_addr <= bus_addr + ADDR_W'(take);
            if (last) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          state  <= ST_RUN;
          bus_as <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sized_bus_master.sv
module sized_bus_master #(
  parameter int ADDR_W = 24,
  parameter int LANES  = 4,
  localparam int CNT_W  = $clog2(LANES + 1),
  localparam int SZ_W   = $clog2(LANES),
  localparam int DATA_W = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SZ_W-1:0]   req_size,
  input  logic              req_write,
  input  logic [2:0]        req_space,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [SZ_W-1:0]   bus_siz,
  output logic [2:0]        bus_fc,
  output logic              bus_rw,
  output logic              bus_as,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [SZ_W-1:0]   bus_ack,
  input  logic [DATA_W-1:0] bus_din,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  logic             acked;
  logic [CNT_W-1:0] take;
  logic [CNT_W-1:0] rem_next;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] load_cnt;
  logic             accept;
  logic             step;
  logic             last_rd;

  sbm_step #(.LANES(LANES), .CNT_W(CNT_W), .SZ_W(SZ_W)) u_step (
    .rem      (rem_q),
    .bus_ack  (bus_ack),
    .acked    (acked),
    .take     (take),
    .rem_next (rem_next)
  );

  sbm_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .CNT_W(CNT_W), .SZ_W(SZ_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_write (req_write),
    .req_space (req_space),
    .acked     (acked),
    .take      (take),
    .rem_next  (rem_next),
    .req_ready (req_ready),
    .accept    (accept),
    .load_cnt  (load_cnt),
    .step      (step),
    .last_rd   (last_rd),
    .rem_q     (rem_q),
    .bus_addr  (bus_addr),
    .bus_siz   (bus_siz),
    .bus_fc    (bus_fc),
    .bus_rw    (bus_rw),
    .bus_as    (bus_as),
    .done      (done)
  );

  sbm_lanes #(.LANES(LANES), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_lanes (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .wdata    (req_wdata),
    .load_cnt (load_cnt),
    .step     (step),
    .take     (take),
    .din      (bus_din),
    .final_rd (last_rd),
    .dout     (bus_dout),
    .rdata    (rdata)
  );

endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
  parameter int ADDR_W = 24,
  parameter int LANES  = 4,
  localparam int SZ_W   = $clog2(LANES),
  localparam int DATA_W = 8 * LANES
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [SZ_W-1:0]   bus_siz,
  input logic [2:0]        bus_fc,
  input logic              bus_rw,
  input logic              bus_as,
  input logic [DATA_W-1:0] bus_dout,
  input logic [SZ_W-1:0]   bus_ack,
  input logic              done
);

  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
    (bus_as && bus_ack == '0) |=> (bus_as && $stable(bus_addr) && $stable(bus_siz) &&
      $stable(bus_fc) && $stable(bus_rw) && $stable(bus_dout))); // R1

  AST_SPACE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    bus_as |-> (bus_fc == 3'b001 || bus_fc == 3'b010 || bus_fc == 3'b101 ||
                bus_fc == 3'b110 || bus_fc == 3'b111)); // R5

  AST_RW_AT_START: assert property (@(posedge clk) disable iff (rst)
    !$stable(bus_rw) |-> $rose(bus_as)); // R4

  AST_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    (bus_as && bus_ack != '0) |=> !bus_as); // R10

  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !bus_as); // R10

endmodule

bind sized_bus_master sbm_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .bus_addr  (bus_addr),
  .bus_siz   (bus_siz),
  .bus_fc    (bus_fc),
  .bus_rw    (bus_rw),
  .bus_as    (bus_as),
  .bus_dout  (bus_dout),
  .bus_ack   (bus_ack),
  .done      (done)
);

// File: tb/sized_bus_master_tb.sv
module sized_bus_master_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [2:0]  req_space = 3'b001;
  logic [31:0] req_wdata = '0;
  logic [23:0] bus_addr;
  logic [1:0]  bus_siz;
  logic [2:0]  bus_fc;
  logic        bus_rw;
  logic        bus_as;
  logic [31:0] bus_dout;
  logic [1:0]  bus_ack = 2'b00;
  logic [31:0] bus_din = 32'hA5A5_A5A5;
  logic        done;
  logic [31:0] rdata;

  always #10 clk = ~clk;

  sized_bus_master u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_space(req_space), .req_wdata(req_wdata), .bus_addr(bus_addr),
    .bus_siz(bus_siz), .bus_fc(bus_fc), .bus_rw(bus_rw), .bus_as(bus_as),
    .bus_dout(bus_dout), .bus_ack(bus_ack), .bus_din(bus_din),
    .done(done), .rdata(rdata)
  );

  int total = 0;
  int bad = 0;

  // Reference model state
  logic [23:0] q_addr[$];
  logic [1:0]  q_siz[$];
  logic [31:0] q_dout[$];
  logic        exp_wr = 1'b0;
  logic [2:0]  exp_fc = 3'b001;
  logic [31:0] exp_rd = '0;
  logic [1:0]  port_code = 2'b11;
  int          wait_n = 0;
  int          wcnt = 0;
  int          starts = 0;
  int          dones = 0;
  bit          got_done = 0;

  logic        p_as = 1'b0, p_rw = 1'b1, p_done = 1'b0;
  logic [23:0] p_addr = '0;
  logic [1:0]  p_siz = '0;
  logic [2:0]  p_fc = '0;
  logic [31:0] p_dout = '0;

  function automatic logic [7:0] byte_at(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h3C;
  endfunction

  function automatic logic [31:0] din_at(input logic [23:0] a);
    return {byte_at(a), byte_at(a + 24'd1), byte_at(a + 24'd2), byte_at(a + 24'd3)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // Per-clock comparison and slave model
  always @(negedge clk) begin
    logic [1:0] cur_ack;
    cur_ack = bus_ack;
    if (!rst) begin
      if (bus_as && !p_as) begin
        starts++;
        if (q_addr.size() == 0) begin
          chk(0, "R5", "cycle not expected", {8'h0, bus_addr}, 32'h0);
        end else begin
          logic [23:0] ea;
          logic [1:0]  es;
          logic [31:0] ed;
          ea = q_addr.pop_front();
          es = q_siz.pop_front();
          ed = q_dout.pop_front();
          chk(bus_addr == ea, "R2", "cycle address", {8'h0, bus_addr}, {8'h0, ea});
          chk(bus_siz == es, "R3", "size code", {30'h0, bus_siz}, {30'h0, es});
          chk(bus_fc == exp_fc, "R5", "space code", {29'h0, bus_fc}, {29'h0, exp_fc});
          chk(bus_rw == !exp_wr, "R4", "read/write", {31'h0, bus_rw}, {31'h0, !exp_wr});
          if (exp_wr) chk(bus_dout == ed, "R8", "write lanes", bus_dout, ed);
        end
      end else if (bus_as && p_as) begin
        if (cur_ack == 2'b00) begin
          chk(bus_addr == p_addr && bus_siz == p_siz && bus_fc == p_fc &&
              bus_rw == p_rw && bus_dout == p_dout, "R1", "fields moved while waiting (R6)",
              {8'h0, bus_addr}, {8'h0, p_addr});
        end else begin
          chk(0, "R10", "strobe high after ack", 32'h1, 32'h0);
        end
      end
      if (bus_rw !== p_rw && !(bus_as && !p_as))
        chk(0, "R4", "read/write changed outside cycle start", {31'h0, bus_rw}, {31'h0, p_rw});
      if (done) begin
        dones++;
        chk(q_addr.size() == 0, "R10", "cycles left at done", q_addr.size(), 32'h0);
        chk(!p_done, "R10", "done longer than one clock", 32'h1, 32'h0);
        if (!exp_wr) chk(rdata == exp_rd, "R9", "read operand", rdata, exp_rd);
        got_done = 1;
      end
      // Slave: acknowledge after wait_n idle clocks of strobe
      if (bus_as && cur_ack == 2'b00) begin
        if (wcnt >= wait_n) begin
          bus_ack = port_code;
          bus_din = din_at(bus_addr);
        end else begin
          wcnt++;
        end
      end else begin
        bus_ack = 2'b00;
        bus_din = 32'hA5A5_A5A5;
        wcnt = 0;
      end
    end
    p_as = bus_as; p_rw = bus_rw; p_done = done; p_addr = bus_addr;
    p_siz = bus_siz; p_fc = bus_fc; p_dout = bus_dout;
  end

  task automatic run_xfer(input logic [23:0] a, input int nbytes, input bit wr,
                          input logic [2:0] fc, input logic [31:0] wd,
                          input logic [1:0] pc, input int wn);
    int pbytes, rem, n;
    logic [23:0] ca;
    logic [31:0] op, r;
    pbytes = (pc == 2'b01) ? 1 : (pc == 2'b10) ? 2 : 4;
    port_code = pc;
    wait_n = wn;
    exp_wr = wr;
    exp_fc = fc;
    op = wd << (8 * (4 - nbytes));
    rem = nbytes;
    ca = a;
    while (rem > 0) begin
      n = (pbytes < rem) ? pbytes : rem;
      q_addr.push_back(ca);
      q_siz.push_back((rem == 4) ? 2'b00 : 2'(rem));
      q_dout.push_back(op);
      op = op << (8 * n);
      ca = ca + 24'(n);
      rem -= n;
    end
    r = '0;
    for (int i = 0; i < nbytes; i++) r = (r << 8) | {24'h0, byte_at(a + 24'(i))};
    exp_rd = r;
    got_done = 0;
    while (!req_ready) begin @(negedge clk); #1; end
    req_addr = a;
    req_size = (nbytes == 4) ? 2'b00 : 2'(nbytes);
    req_write = wr;
    req_space = fc;
    req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk); #1;
    req_valid = 1'b0;
    while (!got_done) begin @(negedge clk); #1; end
  endtask

  task automatic try_reserved(input logic [2:0] fc);
    int s0, d0;
    s0 = starts;
    d0 = dones;
    req_space = fc;
    req_valid = 1'b1;
    @(negedge clk); #1;
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    chk(starts == s0 && dones == d0 && req_ready && !bus_as, "R5", "reserved space ignored",
        starts - s0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk); #1;
    chk(!bus_as && !done, "R10", "reset strobe/done", {30'h0, bus_as, done}, 32'h0);
    chk(req_ready, "R10", "ready after reset", {31'h0, req_ready}, 32'h1);
    chk(bus_rw, "R4", "read/write reset level", {31'h0, bus_rw}, 32'h1);

    run_xfer(24'h001000, 4, 0, 3'b101, 32'h0, 2'b11, 0);         // R7 one wide cycle
    run_xfer(24'h012345, 4, 0, 3'b001, 32'h0, 2'b01, 1);         // R3 four byte cycles
    run_xfer(24'h0ABCD1, 3, 0, 3'b010, 32'h0, 2'b10, 2);         // R7 three bytes on 16-bit
    run_xfer(24'h200000, 4, 1, 3'b110, 32'hCAFE_F00D, 2'b10, 0); // R8 write, rw toggles
    run_xfer(24'h200101, 2, 1, 3'b001, 32'h0000_BEEF, 2'b01, 1); // R4 write after write
    run_xfer(24'h300003, 3, 1, 3'b111, 32'h0012_3456, 2'b11, 0); // R8 three bytes wide
    run_xfer(24'h300010, 1, 1, 3'b101, 32'h0000_0077, 2'b10, 0); // R7 one byte wide port
    run_xfer(24'h400020, 1, 0, 3'b101, 32'h0, 2'b11, 40);        // R6 long wait
    run_xfer(24'hFFFFFF, 2, 0, 3'b001, 32'h0, 2'b01, 0);         // R2 address wrap
    run_xfer(24'hFFFFFE, 4, 1, 3'b010, 32'h89AB_CDEF, 2'b10, 1); // R2 wrap on write
    run_xfer(24'h055555, 3, 0, 3'b110, 32'h0, 2'b01, 0);         // R9 packing
    run_xfer(24'h055558, 2, 0, 3'b110, 32'h0, 2'b11, 3);         // R9 short read wide
    try_reserved(3'b000);
    try_reserved(3'b011);
    try_reserved(3'b100);
    run_xfer(24'h0000F0, 4, 0, 3'b111, 32'h0, 2'b10, 0);         // R5 after rejects
    chk(dones == 13, "R10", "completion count", dones, 32'd13);
    summary();
    $finish;
  end

endmodule